// File: doc/BRIEF.md
# Logarithmic-Depth Carry-Lookahead Adder

This block adds two N-bit unsigned or two's-complement operands and an incoming carry. It produces the N-bit sum and the carry out of the top bit. It is purely combinational. The operand width N must be a power of two, and defaults to 16.

The block does not chain carries bit by bit. Each bit first forms its own generate and propagate terms. A balanced binary tree of log2(N) levels then merges neighbouring bit ranges into wider group terms. A return pass down the same tree hands every range its incoming carry. The low half of a range inherits the carry that enters the parent range. The high half gets the carry that leaves the low half, which is formed from the low half's group terms and the parent's carry. The carry-in to the top of the tree therefore sees about 2·log2(N) two-level stages instead of N.

The block is meant to sit inside a wider datapath, such as an ALU or an address generator. That datapath supplies operands and carry-in, and registers the results where its own timing budget requires.

Top module: `cla_adder`

## Requirements
- R1: `sum` equals the low N bits of `a + b + cin`, with the operands treated as unsigned and `cin` worth 1.
- R2: `cout` equals bit N of the exact (N+1)-bit value `a + b + cin`.
- R3: With `a` all ones, `b` zero and `cin` = 1, the carry crosses every bit: `sum` is zero and `cout` is 1.
- R4: A carry generated at bit 0 crosses every higher bit. With `a` = 1, `b` all ones and `cin` = 0, `sum` is zero and `cout` is 1.
- R5: When `a` and `b` are both zero, `cout` is 0, `sum[0]` equals `cin` and all other sum bits are 0.
- R6: When `b` is the bitwise inverse of `a` (every bit propagates), `cout` equals `cin` and every `sum` bit equals the inverse of `cin`.
- R7: The results of R1 and R2 hold for every width N that is a power of two and at least 2. This covers N = 8, 16 and 32. Any other N stops elaboration with an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First operand |
| b | input | N | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | N | Low N bits of a + b + cin |
| cout | output | 1 | Carry out of bit N-1 |

## Verification
The checker assumes that every operand and carry bit is a known 0 or 1. It evaluates only while that is true, so the unknown inputs before the bench drives them are skipped. Apart from that, the checker assumes nothing about the operand values, and all combinations are legal. The bench first holds each input set steady for a settling interval before it samples. It then covers the 8-bit instance exhaustively over both carry-in values, runs a directed table and random operands on the 16-bit instance, and uses random operands on the 32-bit instance.

// File: rtl/cla_pkg.sv
package cla_pkg;

  // True when n is a power of two and at least 2.
  function automatic bit width_ok(input int n);
    return (n >= 2) && ((n & (n - 1)) == 0);
  endfunction

endpackage

// File: rtl/cla_bit_terms.sv
module cla_bit_terms #(
  parameter int N = 16
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] gen,
  output logic [N-1:0] prop
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign gen[i]  = a[i] & b[i];
    assign prop[i] = a[i] ^ b[i];
  end

endmodule

// File: rtl/cla_node.sv
// One tree node: folds two adjacent ranges into one group on the way up,
// and splits the incoming carry into the two halves on the way down.
module cla_node (
  input  logic lo_g,
  input  logic lo_p,
  input  logic hi_g,
  input  logic hi_p,
  input  logic c_in,
  output logic grp_g,
  output logic grp_p,
  output logic c_lo,
  output logic c_hi
);

  assign grp_g = hi_g | (hi_p & lo_g);
  assign grp_p = lo_p & hi_p;
  assign c_lo  = c_in;
  assign c_hi  = lo_g | (lo_p & c_in);

endmodule

// File: rtl/cla_tree.sv
// Heap-indexed tree: node 1 is the root, node k has children 2k (lower
// bits) and 2k+1 (upper bits), leaf N+i holds bit i.
module cla_tree #(
  parameter int N = 16
) (
  input  logic [N-1:0] gen,
  input  logic [N-1:0] prop,
  input  logic         cin,
  output logic [N-1:0] carry,
  output logic         all_g,
  output logic         all_p
);

  localparam int NODES = 2 * N;

  logic ng [1:NODES-1];
  logic np [1:NODES-1];
  logic nc [1:NODES-1];

  for (genvar i = 0; i < N; i++) begin : g_leaf
    assign ng[N+i]  = gen[i];
    assign np[N+i]  = prop[i];
    assign carry[i] = nc[N+i];
  end

  for (genvar k = 1; k < N; k++) begin : g_node
    cla_node u_node (
      .lo_g  (ng[2*k]),
      .lo_p  (np[2*k]),
      .hi_g  (ng[2*k+1]),
      .hi_p  (np[2*k+1]),
      .c_in  (nc[k]),
      .grp_g (ng[k]),
      .grp_p (np[k]),
      .c_lo  (nc[2*k]),
      .c_hi  (nc[2*k+1])
    );
  end

  assign nc[1] = cin;
  assign all_g = ng[1];
  assign all_p = np[1];

endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int N = 16
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         cout
);
  import cla_pkg::*;

  if (!width_ok(N)) begin : g_bad_width
    $error("cla_adder: N must be a power of two and at least 2");
  end

  logic [N-1:0] gen;
  logic [N-1:0] prop;
  logic [N-1:0] carry;
  logic         all_g;
  logic         all_p;

  cla_bit_terms #(.N(N)) u_terms (
    .a    (a),
    .b    (b),
    .gen  (gen),
    .prop (prop)
  );

  cla_tree #(.N(N)) u_tree (
    .gen   (gen),
    .prop  (prop),
    .cin   (cin),
    .carry (carry),
    .all_g (all_g),
    .all_p (all_p)
  );

  assign sum  = prop ^ carry;
  assign cout = all_g | (all_p & cin);

endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk #(
  parameter int N = 16
) (
  input logic [N-1:0] a,
  input logic [N-1:0] b,
  input logic         cin,
  input logic [N-1:0] sum,
  input logic         cout
);

  logic         known;
  logic [N:0]   exact;

  assign known = !$isunknown({a, b, cin});
  assign exact = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin};

  always_comb begin
    if (known) begin
      // R1
      sum_value_chk: assert (sum == exact[N-1:0]);
      // R2
      carry_out_chk: assert (cout == exact[N]);
      // R5
      zero_ops_chk: assert (!(a == '0 && b == '0) ||
                            (cout == 1'b0 && sum == {{(N-1){1'b0}}, cin}));
      // R6
      full_prop_chk: assert (!(b == ~a) ||
                             (cout == cin && sum == {N{~cin}}));
    end
  end

endmodule

bind cla_adder cla_adder_chk #(.N(N)) u_chk (
  .a    (a),
  .b    (b),
  .cin  (cin),
  .sum  (sum),
  .cout (cout)
);

// File: tb/sim_cla_adder.sv
`timescale 1ns/1ps
module sim_cla_adder;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [15:0] a16, b16, s16;
  logic        c16, co16;
  logic [7:0]  a8, b8, s8;
  logic        c8, co8;
  logic [31:0] a32, b32, s32;
  logic        c32, co32;

  cla_adder #(.N(16)) u0 (.a(a16), .b(b16), .cin(c16), .sum(s16), .cout(co16));
  cla_adder #(.N(8))  u1 (.a(a8),  .b(b8),  .cin(c8),  .sum(s8),  .cout(co8));
  cla_adder #(.N(32)) u2 (.a(a32), .b(b32), .cin(c32), .sum(s32), .cout(co32));

  typedef struct packed {
    logic [15:0] a;
    logic [15:0] b;
    logic        c;
    logic [16:0] exp;
  } vec_t;

  localparam vec_t TBL [10] = '{
    '{16'h0000, 16'h0000, 1'b0, 17'h00000},  // R5
    '{16'hFFFF, 16'h0001, 1'b0, 17'h10000},  // R1 R2
    '{16'hFFFF, 16'h0000, 1'b1, 17'h10000},  // R3
    '{16'h1234, 16'h4321, 1'b0, 17'h05555},  // R1
    '{16'h8000, 16'h8000, 1'b0, 17'h10000},  // R2
    '{16'h7FFF, 16'h0001, 1'b0, 17'h08000},  // R1
    '{16'hAAAA, 16'h5555, 1'b1, 17'h10000},  // R6
    '{16'hAAAA, 16'h5555, 1'b0, 17'h0FFFF},  // R6
    '{16'h00FF, 16'h0F0F, 1'b1, 17'h0100F},  // R1
    '{16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF}   // R2
  };

  task automatic check(input string req, input logic [32:0] act,
                       input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive16(input logic [15:0] x, input logic [15:0] y,
                         input logic c);
    a16 = x; b16 = y; c16 = c;
    #1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    a16 = '0; b16 = '0; c16 = 1'b0;
    a8 = '0; b8 = '0; c8 = 1'b0;
    a32 = '0; b32 = '0; c32 = 1'b0;
    #3;

    // Idle inputs: R5 on all three widths
    check("R5 idle n16", {16'h0, co16, s16}, 33'h0);
    check("R5 idle n8",  {24'h0, co8, s8},   33'h0);
    check("R5 idle n32", {co32, s32},        33'h0);

    // Table walk, 16-bit (R1 R2 R3 R5 R6)
    foreach (TBL[i]) begin
      drive16(TBL[i].a, TBL[i].b, TBL[i].c);
      check("R1 R2 table", {16'h0, co16, s16}, {16'h0, TBL[i].exp});
    end

    // R4: generate at bit 0 crosses all higher bits
    drive16(16'h0001, 16'hFFFF, 1'b0);
    check("R4 n16", {16'h0, co16, s16}, 33'h10000);
    a32 = 32'h1; b32 = 32'hFFFF_FFFF; c32 = 1'b0; #1;
    check("R4 n32", {co32, s32}, 33'h1_0000_0000);

    // R3 on 32-bit
    a32 = 32'hFFFF_FFFF; b32 = '0; c32 = 1'b1; #1;
    check("R3 n32", {co32, s32}, 33'h1_0000_0000);

    // R5 with carry in
    drive16(16'h0, 16'h0, 1'b1);
    check("R5 cin n16", {16'h0, co16, s16}, 33'h00001);

    // R6 with a nontrivial pattern on 8-bit
    a8 = 8'h3C; b8 = 8'hC3; c8 = 1'b0; #1;
    check("R6 n8", {24'h0, co8, s8}, 33'h000FF);

    // R7 exhaustive 8-bit, both carry values
    for (int c = 0; c < 2; c++) begin
      for (int x = 0; x < 256; x++) begin
        for (int y = 0; y < 256; y++) begin
          logic [8:0] e;
          a8 = x[7:0]; b8 = y[7:0]; c8 = c[0];
          #1;
          e = 9'(x) + 9'(y) + 9'(c);
          check("R7 R1 R2 exhaustive n8", {24'h0, co8, s8}, {24'h0, e});
        end
      end
    end

    // R7 random 16-bit and 32-bit
    for (int i = 0; i < 2000; i++) begin
      logic [16:0] e16;
      logic [32:0] e32;
      logic [31:0] r;
      a16 = 16'($urandom); b16 = 16'($urandom); c16 = 1'($urandom);
      a32 = $urandom; b32 = $urandom; c32 = 1'($urandom);
      r = $urandom;
      if (r[3:0] == 4'h0) b32 = ~a32;
      #1;
      e16 = {1'b0, a16} + {1'b0, b16} + {16'h0, c16};
      e32 = {1'b0, a32} + {1'b0, b32} + {32'h0, c32};
      check("R7 R1 R2 random n16", {16'h0, co16, s16}, {16'h0, e16});
      check("R7 R1 R2 random n32", {co32, s32}, e32);
    end

    finish_run();
  end

endmodule